// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM. The word is 36 bits wide and split into four 9-bit byte lanes. Every control and address input is captured on the rising clock edge. A read returns its word from an output register one edge after the command is captured. A write takes its data two active edges after its command. Because the read and write data slots fall in the same cycle, reads and writes can be issued on alternate cycles, or back to back, with no idle cycles on the shared data bus. The bidirectional bus is split into `data_in`, `data_out` and a single drive enable, `data_oe`.

A command is either loaded from the address pins or continues the current four-beat burst. A separate counter module makes the burst addresses, and a parameter chooses between linear and interleaved order. There is an active-low clock enable that freezes the whole block. Writes are masked per lane, and a write with no lane enabled acts as an abort. Output enable is asynchronous. The sleep request takes two edges to put the block to sleep and two edges to wake it. The memory keeps its contents while the block is asleep.

Top module: `pipe_burst_sram`

## Requirements
- R1: When the block captures a load command (`load_n`=0) with the chip selected and `wr_n`=1, `data_out` holds the addressed word in the cycle after the next active edge, with `data_oe`=1 if `out_en_n`=0.
- R2: When the block captures a load or continue command of write type, `data_in` is sampled at the second active edge after it. Lane i, which is bits 9i+8 down to 9i, is written only when `lane_wr_n[i]`=0 in the command cycle. The other lanes keep their old contents.
- R3: A write command with `lane_wr_n`=4'b1111 changes no stored bit, and the bus is not driven for it.
- R4: An edge with `clk_en_n`=1 is ignored. The command is not captured, pending write data is not sampled, and `data_out` keeps its value.
- R5: When `load_n`=1, the operation type of the last load is repeated. The address keeps its bits above bit 1, and the two low bits go start+1, start+2, start+3 modulo 4 (linear, the default). When `BURST_INTERLEAVED`=1, the low bits are start XOR count instead.
- R6: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. When a deselected load is captured, the bus is not driven in the cycle after the next active edge. Continue commands that follow a deselected load write nothing.
- R7: `data_oe` is 0 while `out_en_n`=1, and 0 in the data slot of a write, whatever `out_en_n` is.
- R8: A read returns the result of every write captured before it, including a write captured on the edge just before the read.
- R9: If `sleep_req` is high at an edge and is still high at the next edge, the block is asleep after that second edge. While asleep, `data_oe` is 0, the commands at edges are ignored and in-flight operations are dropped. The block is awake again after the second edge at which `sleep_req` is low, and the stored data is kept.
- R10: After synchronous reset, `data_oe` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Low for write, high for read |
| lane_wr_n | input | 4 | Active-low per-lane write enables, bit i for lane i |
| load_n | input | 1 | Low loads a new command, high continues the burst |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Sleep request |
| addr | input | ADDR_W | Word address |
| data_in | input | 36 | Write data from the bus |
| data_out | output | 36 | Read data to the bus |
| data_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that all inputs are known at every edge. They also assume that the sleep request is raised only after writes in flight have delivered their data, because a write dropped by sleep entry is not modelled. The stimulus keeps to this by issuing deselected loads to drain the pipeline before it raises the sleep request, and by keeping the request low during the random phase. The random phase limits addresses to a small window so that reads often follow writes to the same word and exercise the forwarding path.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lanes;
    } stage_t;

    // Replace the selected lanes of a word with the new data.
    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  lanes
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (lanes[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/pbs_sleep_ctl.sv
module pbs_sleep_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic asleep
);
    logic req_q;

    // Two-edge entry and exit delay.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            asleep <= 1'b0;
        end else begin
            req_q  <= sleep_req;
            asleep <= req_q;
        end
    end
endmodule

// File: rtl/pbs_burst_addr.sv
module pbs_burst_addr #(
    parameter int ADDR_W      = 10,
    parameter int BURST_LEN   = 4,
    parameter bit INTERLEAVED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int CNT_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] start_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  low_nx;

    assign cnt_nx = cnt_q + CNT_W'(1);

    generate
        if (INTERLEAVED) begin : g_interleaved
            assign low_nx = start_q[CNT_W-1:0] ^ cnt_nx;
        end else begin : g_linear
            assign low_nx = start_q[CNT_W-1:0] + cnt_nx;
        end
    endgenerate

    assign burst_addr = {start_q[ADDR_W-1:CNT_W], low_nx};

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (advance) begin
            if (load) begin
                start_q <= start_addr;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/pbs_byte_mem.sv
module pbs_byte_mem
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= lane_merge(store[wr_addr], wr_data, wr_lanes);
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W            = 10,
    parameter bit BURST_INTERLEAVED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              load_n,
    input  logic              out_en_n,
    input  logic              sleep_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] data_out,
    output logic              data_oe
);
    localparam int BURST_LEN = 4;

    logic              asleep;
    logic              active;
    logic              chip_sel;
    logic [ADDR_W-1:0] burst_addr;

    op_e               burst_op_q;
    stage_t            cmd_d, s1_q, s2_q;
    logic [ADDR_W-1:0] addr_d, s1_addr_q, s2_addr_q;
    logic              rd_vld_q;
    logic [WORD_W-1:0] dout_q;

    logic              mem_wr;
    logic [WORD_W-1:0] mem_rd;
    logic              fwd_hit;
    logic [WORD_W-1:0] rd_word;

    pbs_sleep_ctl u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .asleep    (asleep)
    );

    assign active   = ~clk_en_n & ~asleep;
    assign chip_sel = ~sel_a_n & sel_b & ~sel_c_n;

    pbs_burst_addr #(
        .ADDR_W      (ADDR_W),
        .BURST_LEN   (BURST_LEN),
        .INTERLEAVED (BURST_INTERLEAVED)
    ) u_burst (
        .clk        (clk),
        .rst        (rst),
        .advance    (active),
        .load       (~load_n),
        .start_addr (addr),
        .burst_addr (burst_addr)
    );

    // Command decode: a load takes the pins, a continue repeats the burst type.
    always_comb begin
        if (!load_n) begin
            if (!chip_sel)  cmd_d.op = OP_IDLE;
            else if (wr_n)  cmd_d.op = OP_READ;
            else            cmd_d.op = OP_WRITE;
            addr_d = addr;
        end else begin
            cmd_d.op = burst_op_q;
            addr_d   = burst_addr;
        end
        cmd_d.lanes = (cmd_d.op == OP_WRITE) ? ~lane_wr_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || asleep) begin
            burst_op_q <= OP_IDLE;
        end else if (active && !load_n) begin
            burst_op_q <= cmd_d.op;
        end
    end

    // Write data arrives with the stage-2 command; reads fetch from stage 1.
    assign mem_wr  = active && (s2_q.op == OP_WRITE) && (|s2_q.lanes);
    assign fwd_hit = mem_wr && (s2_addr_q == s1_addr_q);
    assign rd_word = fwd_hit ? lane_merge(mem_rd, data_in, s2_q.lanes) : mem_rd;

    pbs_byte_mem #(
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk      (clk),
        .wr_en    (mem_wr),
        .wr_addr  (s2_addr_q),
        .wr_lanes (s2_q.lanes),
        .wr_data  (data_in),
        .rd_addr  (s1_addr_q),
        .rd_data  (mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst || asleep) begin
            s1_q      <= '{op: OP_IDLE, lanes: '0};
            s2_q      <= '{op: OP_IDLE, lanes: '0};
            s1_addr_q <= '0;
            s2_addr_q <= '0;
            rd_vld_q  <= 1'b0;
            if (rst) dout_q <= '0;
        end else if (active) begin
            s1_q      <= cmd_d;
            s1_addr_q <= addr_d;
            s2_q      <= s1_q;
            s2_addr_q <= s1_addr_q;
            rd_vld_q  <= (s1_q.op == OP_READ);
            if (s1_q.op == OP_READ) dout_q <= rd_word;
        end
    end

    assign data_out = dout_q;
    assign data_oe  = rd_vld_q & ~out_en_n & ~asleep;

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        clk_en_n,
    input logic        sel_a_n,
    input logic        sel_b,
    input logic        sel_c_n,
    input logic        wr_n,
    input logic        load_n,
    input logic        sleep_req,
    input logic [35:0] data_out,
    input logic        data_oe
);
    logic [1:0] since_rst;
    logic       sel_w;

    assign sel_w = ~sel_a_n & sel_b & ~sel_c_n;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R4: a stalled edge leaves the read register untouched
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(data_out));

    // R6: a deselected load followed by an active edge leaves the bus undriven
    a_r6_desel_dark: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !clk_en_n && $past(!clk_en_n && !load_n && !sel_w))
        |=> !data_oe);

    // R7: the data slot of a write is never driven
    a_r7_write_slot_dark: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !clk_en_n && $past(!clk_en_n && !load_n && sel_w && !wr_n))
        |=> !data_oe);

    // R9: two edges of sleep request turn the bus off
    a_r9_sleep_dark: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(sleep_req)) |=> !data_oe);

endmodule

bind pipe_burst_sram pbs_checker u_pbs_checker (
    .clk       (clk),
    .rst       (rst),
    .clk_en_n  (clk_en_n),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .wr_n      (wr_n),
    .load_n    (load_n),
    .sleep_req (sleep_req),
    .data_out  (data_out),
    .data_oe   (data_oe)
);

// File: tb/pipe_burst_sram_test.sv
`timescale 1ns/1ps
module pipe_burst_sram_test;

    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        clk_en_n, sel_a_n, sel_b, sel_c_n, wr_n, load_n, out_en_n, sleep_req;
    logic [3:0]  lane_wr_n;
    logic [AW-1:0] addr;
    logic [35:0] data_in;
    logic [35:0] data_out;
    logic        data_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pipe_burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .load_n(load_n),
        .out_en_n(out_en_n), .sleep_req(sleep_req), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    typedef struct {
        int          kind;   // 0 none, 1 read, 2 write
        logic [AW-1:0] a;
        logic [35:0] data;
        logic [35:0] exp;
    } rec_t;

    logic [35:0] model [64];
    rec_t        p1, p2;
    int          b_kind;
    logic [AW-1:0] b_start;
    logic [1:0]  b_cnt;
    bit          zb1, zb2;

    // command fields for the next tick
    bit          c_stall, c_ld, c_sel, c_we, c_oe_n, c_zz;
    logic [3:0]  c_bw_n;
    logic [AW-1:0] c_addr;
    logic [35:0] c_data;
    string       c_tag;

    function automatic logic [35:0] rnd36();
        return {4'($urandom()), 32'($urandom())};
    endfunction

    function automatic logic [1:0] burst_low(input logic [1:0] base, input logic [1:0] cnt);
        return base + cnt;   // linear order, R5
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        rec_t cur;
        bit   asleep_now;
        bit   exp_oe;
        logic [35:0] prev_out;
        cur.kind = 0; cur.a = '0; cur.data = '0; cur.exp = '0;
        asleep_now = zb2;
        clk_en_n  = c_stall;
        load_n    = c_ld ? 1'b0 : 1'b1;
        wr_n      = ~c_we;
        lane_wr_n = c_bw_n;
        out_en_n  = c_oe_n;
        sleep_req = c_zz;
        addr      = c_addr;
        if (c_sel) {sel_a_n, sel_b, sel_c_n} = 3'b010;
        else begin
            case ($urandom() % 3)
                0:       {sel_a_n, sel_b, sel_c_n} = 3'b110;
                1:       {sel_a_n, sel_b, sel_c_n} = 3'b000;
                default: {sel_a_n, sel_b, sel_c_n} = 3'b011;
            endcase
        end
        data_in = (p2.kind == 2) ? p2.data : rnd36();
        if (!c_stall && !asleep_now) begin
            if (c_ld) begin
                cur.kind = c_sel ? (c_we ? 2 : 1) : 0;
                cur.a    = c_addr;
                b_kind   = cur.kind;
                b_start  = c_addr;
                b_cnt    = 2'd0;
            end else begin
                b_cnt    = b_cnt + 2'd1;
                cur.kind = b_kind;
                cur.a    = {b_start[AW-1:2], burst_low(b_start[1:0], b_cnt)};
            end
            if (cur.kind == 2) begin
                cur.data = c_data;
                for (int i = 0; i < 4; i++)
                    if (!c_bw_n[i]) model[cur.a[5:0]][i*9 +: 9] = c_data[i*9 +: 9];
            end else if (cur.kind == 1) begin
                cur.exp = model[cur.a[5:0]];
            end
        end
        prev_out = data_out;
        @(posedge clk);
        zb2 = zb1;
        zb1 = c_zz;
        if (asleep_now) begin
            p1.kind = 0; p2.kind = 0; b_kind = 0;
        end else if (!c_stall) begin
            p2 = p1;
            p1 = cur;
        end
        @(negedge clk);
        if (c_stall && !asleep_now)
            check(data_out === prev_out, {"R4 stall hold ", c_tag}, data_out, prev_out);
        exp_oe = (p2.kind == 1) && !c_oe_n && !zb2;
        if (exp_oe) begin
            check(data_oe === 1'b1, {"R1 drive ", c_tag}, {35'd0, data_oe}, 36'd1);
            check(data_out === p2.exp, {"R1/R8 data ", c_tag}, data_out, p2.exp);
        end else begin
            check(data_oe === 1'b0, {"R7/R6 dark ", c_tag}, {35'd0, data_oe}, 36'd0);
        end
    endtask

    task automatic set_idle();
        c_stall = 0; c_ld = 1; c_sel = 0; c_we = 0; c_oe_n = 0; c_zz = 0;
        c_bw_n = 4'hF; c_addr = '0; c_data = '0;
    endtask

    task automatic cmd_rd(input logic [AW-1:0] a, input string tag);
        set_idle(); c_sel = 1; c_addr = a; c_tag = tag; tick();
    endtask

    task automatic cmd_wr(input logic [AW-1:0] a, input logic [3:0] bw, input logic [35:0] d, input string tag);
        set_idle(); c_sel = 1; c_we = 1; c_addr = a; c_bw_n = bw; c_data = d; c_tag = tag; tick();
    endtask

    task automatic cmd_cont(input bit we, input logic [3:0] bw, input logic [35:0] d, input string tag);
        set_idle(); c_ld = 0; c_we = we; c_bw_n = bw; c_data = d; c_tag = tag; tick();
    endtask

    task automatic cmd_desel(input string tag);
        set_idle(); c_addr = AW'($urandom() % 64); c_tag = tag; tick();
    endtask

    task automatic cmd_stall(input string tag);
        set_idle(); c_stall = 1; c_ld = 0; c_tag = tag; tick();
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        p1.kind = 0; p2.kind = 0; b_kind = 0; b_start = '0; b_cnt = '0; zb1 = 0; zb2 = 0;
        set_idle();
        clk_en_n = 0; load_n = 0; wr_n = 1; lane_wr_n = 4'hF; out_en_n = 0;
        sleep_req = 0; addr = '0; data_in = '0;
        {sel_a_n, sel_b, sel_c_n} = 3'b110;
        rst = 1;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state, bus not driven
        check(data_oe === 1'b0, "R10 reset", {35'd0, data_oe}, 36'd0);

        // R2: fill the test window with full-word writes
        for (int i = 0; i < 64; i++) cmd_wr(AW'(i), 4'h0, rnd36(), "R2 fill");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");
        for (int i = 0; i < 8; i++) cmd_rd(AW'(i), "R1 readback");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R2 lanes and R8 back-to-back forwarding
        cmd_wr(5, 4'h0, 36'h1_2345_6789, "R2 full");
        cmd_wr(5, 4'b1010, 36'hA_BCDE_F012, "R2 lanes 0,2");
        cmd_rd(5, "R8 forward");
        cmd_desel("R6 drain");
        cmd_rd(5, "R2 lane merge");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R3: write abort
        cmd_wr(7, 4'hF, 36'hF_FFFF_FFFF, "R3 abort");
        cmd_rd(7, "R3 unchanged");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R5: linear bursts
        cmd_wr(6, 4'h0, rnd36(), "R5 burst wr");
        cmd_cont(1, 4'h0, rnd36(), "R5 burst wr");
        cmd_cont(1, 4'b0110, rnd36(), "R5 burst wr");
        cmd_cont(1, 4'h0, rnd36(), "R5 burst wr");
        cmd_rd(6, "R5 burst rd");
        cmd_cont(0, 4'hF, '0, "R5 burst rd");
        cmd_cont(0, 4'hF, '0, "R5 burst rd");
        cmd_cont(0, 4'hF, '0, "R5 burst rd");
        cmd_cont(0, 4'hF, '0, "R5 wrapped");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R6: continue after deselect writes nothing
        set_idle(); c_addr = 9; c_tag = "R6 desel load"; tick();
        cmd_cont(1, 4'h0, 36'h0_0000_0000, "R6 desel cont");
        cmd_cont(1, 4'h0, 36'h0_0000_0000, "R6 desel cont");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");
        cmd_rd(10, "R6 untouched");
        cmd_rd(11, "R6 untouched");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R7: output enable high hides a read; stall then re-enable
        cmd_rd(3, "R7 setup");
        set_idle(); c_oe_n = 1; c_tag = "R7 oe high"; tick();
        cmd_stall("R7 oe low again");
        cmd_desel("R6 drain");
        cmd_desel("R6 drain");

        // R7/R8: alternating writes and reads, no idle cycles
        cmd_wr(12, 4'h0, rnd36(), "R7 alt");
        cmd_rd(13, "R7 alt");
        cmd_wr(13, 4'h0, rnd36(), "R7 alt");
        cmd_rd(12, "R8 alt");
        cmd_rd(13, "R8 alt");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R4: stalls in the middle of writes and reads
        cmd_wr(20, 4'h0, rnd36(), "R4 wr");
        cmd_stall("R4");
        cmd_stall("R4");
        cmd_rd(20, "R4 rd after stalled write");
        cmd_stall("R4");
        cmd_desel("R4");
        cmd_stall("R4 hold data");
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        // R9: sleep entry, ignored commands, exit
        cmd_rd(1, "R9 pre");
        set_idle(); c_sel = 1; c_addr = 2; c_zz = 1; c_tag = "R9 still awake"; tick();
        set_idle(); c_zz = 1; c_tag = "R9 entered"; tick();
        set_idle(); c_sel = 1; c_we = 1; c_bw_n = 4'h0; c_addr = 1; c_data = 36'h0;
        c_zz = 1; c_tag = "R9 ignored write"; tick();
        set_idle(); c_zz = 1; c_tag = "R9 asleep"; tick();
        set_idle(); c_sel = 1; c_addr = 2; c_zz = 0; c_tag = "R9 exiting"; tick();
        set_idle(); c_sel = 1; c_addr = 2; c_tag = "R9 exiting"; tick();
        cmd_rd(1, "R9 retained");
        cmd_rd(2, "R9 retained");
        cmd_desel("R9 after"); cmd_desel("R9 after");

        // Random phase
        for (int n = 0; n < 600; n++) begin
            set_idle();
            c_tag   = "R1/R2/R8 random";
            c_stall = ($urandom() % 10) == 0;
            c_ld    = (b_kind == 0) || (($urandom() % 10) < 7);
            c_sel   = ($urandom() % 100) < 85;
            c_we    = $urandom() % 2;
            c_bw_n  = (($urandom() % 100) < 15) ? 4'hF : 4'($urandom());
            c_oe_n  = ($urandom() % 10) == 0;
            c_addr  = AW'($urandom() % 64);
            c_data  = rnd36();
            tick();
        end
        cmd_desel("R6 drain"); cmd_desel("R6 drain");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule